// File: doc/BRIEF.md
# T1 Frame Serializer with Selectable Zero Suppression

This transmit-side block turns a stream of 8-bit channel bytes into 193-bit T1 frames and line-codes the result into a pair of bipolar pulse outputs. Each frame is one framing bit followed by 24 time slots of 8 bits. The line rate is set by a bit strobe: one frame bit advances on every clock edge where `bit_en` is high. At the nominal rate of 1.544 Mbit/s, frames repeat 8000 times per second.

Channel bytes arrive through a one-deep ready/valid holding register, one byte per time slot. The framing bit is taken from `fbit_in` on the strobe that begins each frame. The ones-density method is chosen at run time on `zs_mode`. The choices are plain alternate mark inversion, forced one stuffing of all-zero slots, and eight-zero substitution with bipolar violations. Substitution needs eight bits of look-ahead, so the line outputs trail the serial data by exactly eight strobes in every mode.

Top module: `t1_zs_tx`

## Requirements
- R1: While `rst_n` is low, `line_pos`, `line_neg` and `frame_start` are low and `byte_ready` is high.
- R2: Each frame has 193 bits. The framing bit comes first, followed by slots 1 to 24 in order, each sent most significant bit first. A data bit sent on strobe n reaches the line outputs on strobe n+8.
- R3: `frame_start` is high exactly for the line bit period that carries a framing bit, so it recurs every 193 strobes.
- R4: With `zs_mode` equal to 2'b00 (and likewise for 2'b11), every one becomes a pulse of opposite polarity to the previous pulse and every zero becomes no pulse. The first pulse after reset is positive (`line_pos`).
- R5: With `zs_mode` equal to 2'b10, each run of eight zeros is sent as 0,0,0,V,B,0,V,B. V is a pulse of the same polarity as the pulse before it; B is a pulse of the opposite polarity. A longer run is replaced in successive groups of eight.
- R6: The zero-run count and the pulse polarity carry across slot and frame boundaries, so a run that spans a framing bit or a slot edge is substituted like any other.
- R7: With `zs_mode` equal to 2'b01, a slot whose byte is 8'h00 is sent as 8'h01, and other bytes are sent unchanged. Substitution is applied only under 2'b10.
- R8: `line_pos` and `line_neg` are never high together, and all three line outputs change only on a clock edge where `bit_en` is high.
- R9: A byte is taken when `byte_valid` and `byte_ready` are both high. `byte_ready` then stays low until the byte is consumed at its slot start. A slot that starts with no byte held is sent as all zeros.
- R10: During the first eight strobes after reset no pulse and no `frame_start` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit strobe; one line bit per high cycle |
| zs_mode | input | 2 | 00/11 AMI, 01 forced one stuffing, 10 eight-zero substitution |
| fbit_in | input | 1 | Framing bit value, sampled on the frame's first strobe |
| byte_in | input | 8 | Channel byte for the next time slot |
| byte_valid | input | 1 | `byte_in` holds a byte |
| byte_ready | output | 1 | Holding register is empty |
| line_pos | output | 1 | Positive pulse output |
| line_neg | output | 1 | Negative pulse output |
| frame_start | output | 1 | High while the framing bit is on the line |

## Verification
Two functions can act in the same line period. An eight-zero substitution can span a frame boundary, so that a framing bit lies inside a replaced run, and a violation pulse can go out while `frame_start` is high. Both are provoked by sending all-zero slots with framing bits that alternate between 0 and 1. Runs then straddle the framing bit on every other frame. The bench checks every line period against its own encoding of the bit stream, which it builds with a greedy zero-run count over the whole frame sequence. It checks polarity, frame marking and the placement of V and B together.

// File: rtl/t1zs_pkg.sv
package t1zs_pkg;
   // Symbol held in the look-ahead window
   typedef enum logic [1:0] {
      SYM_ZERO = 2'd0,
      SYM_MARK = 2'd1,
      SYM_VIOL = 2'd2,
      SYM_IDLE = 2'd3
   } sym_e;

   // Ones-density method selected at run time
   typedef enum logic [1:0] {
      ZS_AMI   = 2'b00,
      ZS_STUFF = 2'b01,
      ZS_B8ZS  = 2'b10,
      ZS_RSVD  = 2'b11
   } zs_mode_e;
endpackage

// File: rtl/t1zs_slot_ser.sv
module t1zs_slot_ser #(
   parameter int SLOTS  = 24,
   parameter int SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              stuff_en,
   input  logic              fbit_in,
   input  logic [SLOT_W-1:0] byte_in,
   input  logic              byte_valid,
   output logic              byte_ready,
   output logic              ser_bit,
   output logic              ser_fstart
);
   localparam int FRAME_BITS = 1 + SLOTS * SLOT_W;
   localparam int PW         = $clog2(FRAME_BITS);
   localparam int SBW        = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

   logic [PW-1:0]     pos_q;
   logic [SBW-1:0]    sb_q;
   logic [SLOT_W-1:0] hold_q;
   logic              full_q;
   logic [SLOT_W-1:0] shr_q;
   logic [SLOT_W-1:0] slot_word;
   logic              at_fbit;
   logic              at_slot0;

   assign at_fbit  = (pos_q == '0);
   assign at_slot0 = !at_fbit && (sb_q == '0);
   assign byte_ready = !full_q;

   always_comb begin
      slot_word = full_q ? hold_q : '0;
      if (stuff_en && (slot_word == '0))
         slot_word = SLOT_W'(1);
   end

   always_comb begin
      if (at_fbit)       ser_bit = fbit_in;
      else if (at_slot0) ser_bit = slot_word[SLOT_W-1];
      else               ser_bit = shr_q[SLOT_W-1];
   end
   assign ser_fstart = at_fbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         sb_q   <= '0;
         hold_q <= '0;
         full_q <= 1'b0;
         shr_q  <= '0;
      end else begin
         if (byte_valid && !full_q) begin
            hold_q <= byte_in;
            full_q <= 1'b1;
         end else if (bit_en && at_slot0) begin
            full_q <= 1'b0;
         end
         if (bit_en) begin
            pos_q <= (pos_q == PW'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
            if (!at_fbit)
               sb_q <= (sb_q == SBW'(SLOT_W - 1)) ? '0 : sb_q + 1'b1;
            if (at_slot0) shr_q <= slot_word << 1;
            else          shr_q <= shr_q << 1;
         end
      end
   end
endmodule

// File: rtl/t1zs_subst_win.sv
module t1zs_subst_win
   import t1zs_pkg::*;
#(
   parameter int RUN     = 8,
   parameter bit HAS_SUB = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic sub_en,
   input  logic din,
   input  logic fin,
   output sym_e sym_out,
   output logic fs_out
);
   sym_e           win_q [RUN];
   sym_e           win_d [RUN];
   logic [RUN-1:0] fwin_q;
   logic           sub_ok;
   logic           all_zero;

   // Replacement pattern, index RUN-1 is the oldest bit
   function automatic sym_e sub_sym(input int idx);
      case (idx)
         0, 3:    sub_sym = SYM_MARK;
         1, 4:    sub_sym = SYM_VIOL;
         default: sub_sym = SYM_ZERO;
      endcase
   endfunction

   generate
      if (HAS_SUB) begin : g_sub
         if (RUN != 8) begin : g_bad_run
            $error("substitution window must be eight bits");
         end
         assign sub_ok = sub_en;
      end else begin : g_nosub
         assign sub_ok = sub_en & 1'b0;
      end
   endgenerate

   always_comb begin
      win_d[0] = din ? SYM_MARK : SYM_ZERO;
      for (int i = 1; i < RUN; i++) win_d[i] = win_q[i-1];
      all_zero = 1'b1;
      for (int i = 0; i < RUN; i++)
         if (win_d[i] != SYM_ZERO) all_zero = 1'b0;
      if (sub_ok && all_zero)
         for (int i = 0; i < RUN; i++) win_d[i] = sub_sym(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RUN; i++) win_q[i] <= SYM_IDLE;
         fwin_q <= '0;
      end else if (bit_en) begin
         for (int i = 0; i < RUN; i++) win_q[i] <= win_d[i];
         fwin_q <= {fwin_q[RUN-2:0], fin};
      end
   end

   assign sym_out = win_q[RUN-1];
   assign fs_out  = fwin_q[RUN-1];
endmodule

// File: rtl/t1zs_line_enc.sv
module t1zs_line_enc
   import t1zs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  sym_e sym_in,
   input  logic fs_in,
   output logic line_pos,
   output logic line_neg,
   output logic frame_start
);
   // pol_q: 1 when the last pulse was negative
   logic pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q       <= 1'b1;
         line_pos    <= 1'b0;
         line_neg    <= 1'b0;
         frame_start <= 1'b0;
      end else if (bit_en) begin
         frame_start <= fs_in;
         case (sym_in)
            SYM_MARK: begin
               pol_q    <= ~pol_q;
               line_pos <= pol_q;
               line_neg <= ~pol_q;
            end
            SYM_VIOL: begin
               line_pos <= ~pol_q;
               line_neg <= pol_q;
            end
            default: begin
               line_pos <= 1'b0;
               line_neg <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/t1_zs_tx.sv
module t1_zs_tx
   import t1zs_pkg::*;
#(
   parameter int SLOTS    = 24,
   parameter int SLOT_W   = 8,
   parameter bit HAS_B8ZS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        zs_mode,
   input  logic              fbit_in,
   input  logic [SLOT_W-1:0] byte_in,
   input  logic              byte_valid,
   output logic              byte_ready,
   output logic              line_pos,
   output logic              line_neg,
   output logic              frame_start
);
   localparam int RUN = 8;

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least one");
      end
      if (SLOT_W < 2) begin : g_bad_width
         $error("SLOT_W must be at least two");
      end
   endgenerate

   logic stuff_en;
   logic sub_en;
   logic ser_bit;
   logic ser_fstart;
   sym_e win_sym;
   logic win_fs;

   assign stuff_en = (zs_mode == ZS_STUFF);
   assign sub_en   = (zs_mode == ZS_B8ZS);

   t1zs_slot_ser #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .stuff_en   (stuff_en),
      .fbit_in    (fbit_in),
      .byte_in    (byte_in),
      .byte_valid (byte_valid),
      .byte_ready (byte_ready),
      .ser_bit    (ser_bit),
      .ser_fstart (ser_fstart)
   );

   t1zs_subst_win #(.RUN(RUN), .HAS_SUB(HAS_B8ZS)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .sub_en  (sub_en),
      .din     (ser_bit),
      .fin     (ser_fstart),
      .sym_out (win_sym),
      .fs_out  (win_fs)
   );

   t1zs_line_enc u_enc (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .sym_in      (win_sym),
      .fs_in       (win_fs),
      .line_pos    (line_pos),
      .line_neg    (line_neg),
      .frame_start (frame_start)
   );
endmodule

// File: rtl/t1zs_chk.sv
module t1zs_chk #(
   parameter int FRAME_BITS = 193
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic byte_valid,
   input logic byte_ready,
   input logic line_pos,
   input logic line_neg,
   input logic frame_start
);
   localparam int GW = $clog2(FRAME_BITS + 1) + 1;

   logic [GW-1:0] gap_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (bit_en) begin
         gap_q  <= frame_start ? GW'(1) : gap_q + 1'b1;
         seen_q <= seen_q | frame_start;
      end
   end

   // R8
   no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg));

   // R8
   hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_en) |-> $stable({line_pos, line_neg, frame_start}));

   // R9
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_ready) |=> !byte_ready);

   // R3
   frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(frame_start) && seen_q) |-> (gap_q == GW'(FRAME_BITS)));
endmodule

bind t1_zs_tx t1zs_chk #(.FRAME_BITS(1 + SLOTS * SLOT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .byte_valid  (byte_valid),
   .byte_ready  (byte_ready),
   .line_pos    (line_pos),
   .line_neg    (line_neg),
   .frame_start (frame_start)
);

// File: tb/tb_t1_zs_tx.sv
`timescale 1ns/1ps
module tb_t1_zs_tx;
   localparam int FB   = 193;
   localparam int MAXB = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [1:0] zs_mode = 2'b00;
   logic       fbit_in = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       byte_valid = 1'b0;
   logic       byte_ready;
   logic       line_pos;
   logic       line_neg;
   logic       frame_start;

   int checks = 0;
   int errors = 0;

   logic       e_pos [MAXB];
   logic       e_neg [MAXB];
   int         cur_pid;
   logic       cur_feed;
   int         idx;
   logic       fire;
   int         ncmp;
   string      cur_tag;

   always #5 clk = ~clk;

   t1_zs_tx dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .zs_mode(zs_mode),
      .fbit_in(fbit_in), .byte_in(byte_in), .byte_valid(byte_valid),
      .byte_ready(byte_ready), .line_pos(line_pos), .line_neg(line_neg),
      .frame_start(frame_start)
   );

   function automatic logic [7:0] byte_of(input int pid, input int n);
      case (pid)
         0: byte_of = 8'((n * 37 + 11) ^ (n * 5));
         1: byte_of = 8'h00;
         default: case (n % 4)
            0: byte_of = 8'h80;
            3: byte_of = 8'h01;
            default: byte_of = 8'h00;
         endcase
      endcase
   endfunction

   function automatic logic fb_of(input int pid, input int f);
      fb_of = (pid == 1) ? logic'(f % 2) : logic'((f + pid) % 2);
   endfunction

   task automatic check(input string tag, input logic ok, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Reference encoding built from the requirements over the whole stream
   task automatic build(input logic [1:0] mode, input int nfr);
      int   sym [MAXB];
      logic bits [MAXB];
      int   nb = 0;
      int   zc = 0;
      logic pol = 1'b1;
      for (int f = 0; f <= nfr; f++) begin
         bits[nb++] = fb_of(cur_pid, f);
         for (int s = 0; s < 24; s++) begin
            logic [7:0] b = cur_feed ? byte_of(cur_pid, f * 24 + s) : 8'h00;
            if (mode == 2'b01 && b == 8'h00) b = 8'h01;
            for (int k = 7; k >= 0; k--) bits[nb++] = b[k];
         end
      end
      for (int i = 0; i < nb; i++) begin
         if (bits[i]) begin sym[i] = 1; zc = 0; end
         else begin
            sym[i] = 0; zc++;
            if (mode == 2'b10 && zc == 8) begin
               sym[i-4] = 2; sym[i-3] = 1; sym[i-1] = 2; sym[i] = 1;
               zc = 0;
            end
         end
      end
      for (int i = 0; i < nb; i++) begin
         e_pos[i] = 1'b0; e_neg[i] = 1'b0;
         if (sym[i] == 1) begin
            pol = ~pol; e_pos[i] = ~pol; e_neg[i] = pol;
         end else if (sym[i] == 2) begin
            e_pos[i] = ~pol; e_neg[i] = pol;
         end
      end
   endtask

   task automatic cmp_out(input int k);
      if (line_pos && line_neg)
         check("R8", 1'b0, "both pulses high", 1, 0);
      if (k < 9) begin
         check("R10", {line_pos, line_neg, frame_start} == 3'b000,
               "fill output", int'({line_pos, line_neg, frame_start}), 0);
      end else if (k - 9 < ncmp) begin
         int j = k - 9;
         check(cur_tag, {line_pos, line_neg} == {e_pos[j], e_neg[j]},
               $sformatf("pulse pair bit %0d", j),
               int'({line_pos, line_neg}), int'({e_pos[j], e_neg[j]}));
         check("R3", frame_start == ((j % FB) == 0),
               $sformatf("frame_start bit %0d", j),
               int'(frame_start), int'((j % FB) == 0));
      end
   endtask

   task automatic tick(input logic be, input int chk_k);
      @(negedge clk);
      if (chk_k > 0) cmp_out(chk_k);
      if (fire) begin
         idx++;
         check("R9", byte_ready == 1'b0, "ready after accept", int'(byte_ready), 0);
      end
      byte_in    = byte_of(cur_pid, idx);
      byte_valid = cur_feed;
      fire       = cur_feed && byte_ready;
      bit_en     = be;
   endtask

   task automatic run_stream(input string tag, input logic [1:0] mode,
                             input int pid, input logic feed, input int nfr);
      cur_tag  = tag;
      cur_pid  = pid;
      cur_feed = feed;
      idx      = 0;
      fire     = 1'b0;
      ncmp     = nfr * FB;
      build(mode, nfr);
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; byte_valid = 1'b0; zs_mode = mode;
      repeat (2) @(negedge clk);
      check("R1", {line_pos, line_neg, frame_start, byte_ready} == 4'b0001,
            "reset state", int'({line_pos, line_neg, frame_start, byte_ready}), 1);
      rst_n = 1'b1;
      for (int k = 1; k <= ncmp + 9; k++) begin
         tick(1'b0, k - 1);
         tick(1'b0, 0);
         fbit_in = fb_of(pid, (k - 1) / FB);
         tick(1'b1, 0);
      end
      tick(1'b0, ncmp + 9);
      tick(1'b0, 0);
   endtask

   // R2 R4: AMI on varied data, MSB-first framing
   task automatic t_ami_data();
      run_stream("R2 R4", 2'b00, 0, 1'b1, 2);
   endtask

   // R4: reserved code behaves as AMI; long zero runs left alone
   task automatic t_ami_rsvd();
      run_stream("R4 R7", 2'b11, 2, 1'b1, 2);
   endtask

   // R5 R6: zero slots, runs span framing bits
   task automatic t_b8zs_zeros();
      run_stream("R5 R6", 2'b10, 1, 1'b1, 3);
   endtask

   // R5: runs of 30 zeros across slot edges
   task automatic t_b8zs_mix();
      run_stream("R5", 2'b10, 2, 1'b1, 2);
   endtask

   // R7: forced one stuffing on mixed and all-zero slots
   task automatic t_stuff_mix();
      run_stream("R7", 2'b01, 2, 1'b1, 2);
   endtask

   task automatic t_stuff_zero();
      run_stream("R7", 2'b01, 1, 1'b1, 1);
   endtask

   // R9: no bytes offered, slots go out as zeros
   task automatic t_underrun();
      run_stream("R9", 2'b00, 0, 1'b0, 1);
   endtask

   initial begin
      t_ami_data();
      t_ami_rsvd();
      t_b8zs_zeros();
      t_b8zs_mix();
      t_stuff_mix();
      t_stuff_zero();
      t_underrun();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1500000;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule